// File: doc/BRIEF.md
# Cache Block Pattern Decompressor

This block rebuilds one 128-byte cache block as sixteen 64-bit double-words. Its inputs are a 2-bit block state, a 32-bit pattern header that holds one 2-bit code per double-word, and a packed stream of 32-bit payload words. Each code says how its double-word was reduced: all zero, lower half only, a half that is duplicated or paired with zero, or the full value. The block state selects one of two decoding variants. It can also mark the block as stored raw or as entirely zero.

A block descriptor is accepted on a valid/ready port. The descriptor carries the state, the header and a 32-bit location field, which is in units of 8 bytes. The location is turned into a byte address and held on an output while the block is decoded. Payload words are requested through a second valid/ready port, and only when the current code needs them. Rebuilt double-words leave in order on a third valid/ready port, and the sixteenth is flagged as last. The size of the compressed data is not needed and is not an input.

Top module: `blk_decomp`

## Requirements
- R1: From the cycle after a descriptor is accepted until its last double-word leaves, `blk_addr_o` holds the location field shifted left by 3 (times 8).
- R2: Codes are taken from header bits [31:30] for double-word 0 down to bits [1:0] for double-word 15. Exactly sixteen double-words leave per block, and `dw_last_o` is high only with the sixteenth.
- R3: Code 00 gives a zero double-word and takes no payload word.
- R4: Code 01 takes one word w and gives {32'h0, w}, where w is the lower half.
- R5: Under state 00 (variant I), code 10 takes one word w and gives {w, w}.
- R6: Under state 01 (variant II), code 10 takes one word w and gives {w, 32'h0}.
- R7: Code 11 takes two words. The first is the upper half and the second is the lower half.
- R8: State 10 (raw) ignores the header and takes 32 words, two per double-word, with the upper half first.
- R9: State 11 (all zero) ignores the header, gives sixteen zero double-words and never raises `pay_ready_o`.
- R10: `blk_ready_o` stays low from acceptance until the handshake of the last double-word. It is high again in the next cycle. The number of payload words taken equals the sum the codes call for.
- R11: While `dw_valid_o` is high and `dw_ready_i` is low, `dw_valid_o` stays high and `dw_data_o` stays unchanged.
- R12: After reset, `blk_ready_o` is high and both `dw_valid_o` and `pay_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | Descriptor valid |
| blk_ready_o | output | 1 | Descriptor accepted when high with valid |
| blk_state_i | input | 2 | 00 variant I, 01 variant II, 10 raw, 11 all zero |
| blk_hdr_i | input | 32 | Sixteen 2-bit pattern codes |
| blk_loc_i | input | 32 | Location of compressed data in 8-byte units |
| blk_addr_o | output | 35 | Byte address of compressed data for the current block |
| pay_valid_i | input | 1 | Payload word valid |
| pay_ready_o | output | 1 | Payload word requested |
| pay_data_i | input | 32 | Payload word |
| dw_valid_o | output | 1 | Double-word valid |
| dw_ready_i | input | 1 | Double-word accepted when high with valid |
| dw_data_o | output | 64 | Rebuilt double-word |
| dw_last_o | output | 1 | Sixteenth double-word of the block |

## Verification
A wrong code index or a miscounted word shows up at the first affected double-word handshake. It appears as a wrong value there, and because every later word then lands in the wrong place, the remaining double-words of the block also come out wrong. The bench also compares, at block end, the number of payload words taken against the number the codes call for. A stuck block counter shows as a missing or misplaced last flag, or as `blk_ready_o` returning at the wrong cycle. A drifting output register under backpressure shows in the cycle right after a stall.

// File: rtl/blkd_pkg.sv
package blkd_pkg;
  typedef enum logic [1:0] {
    ST_VAR1 = 2'b00,
    ST_VAR2 = 2'b01,
    ST_RAW  = 2'b10,
    ST_ZERO = 2'b11
  } blk_state_e;

  typedef enum logic [1:0] {
    PC_ZERO = 2'b00,
    PC_LOW  = 2'b01,
    PC_HALF = 2'b10,
    PC_FULL = 2'b11
  } pat_code_e;
endpackage

// File: rtl/blkd_code_sel.sv
module blkd_code_sel
  import blkd_pkg::*;
#(
  parameter int N_DW  = 16,
  localparam int HDR_W = 2 * N_DW,
  localparam int IDX_W = $clog2(N_DW)
) (
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  blk_state_e       state_i,
  output pat_code_e        code_o,
  output logic [1:0]       need_o
);
  logic [HDR_W-1:0] hdr_sh;

  // most significant pair belongs to double-word 0
  assign hdr_sh = hdr_i << {idx_i, 1'b0};

  always_comb begin
    unique case (state_i)
      ST_RAW:  code_o = PC_FULL;
      ST_ZERO: code_o = PC_ZERO;
      default: code_o = pat_code_e'(hdr_sh[HDR_W-1 -: 2]);
    endcase
    unique case (code_o)
      PC_ZERO: need_o = 2'd0;
      PC_FULL: need_o = 2'd2;
      default: need_o = 2'd1;
    endcase
  end
endmodule

// File: rtl/blkd_dw_asm.sv
module blkd_dw_asm
  import blkd_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int DW_W = 2 * WORD_W
) (
  input  pat_code_e         code_i,
  input  logic              var2_i,
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  output logic [DW_W-1:0]   dw_o
);
  always_comb begin
    unique case (code_i)
      PC_ZERO: dw_o = '0;
      PC_LOW:  dw_o = {{WORD_W{1'b0}}, w0_i};
      PC_HALF: dw_o = var2_i ? {w0_i, {WORD_W{1'b0}}} : {w0_i, w0_i};
      default: dw_o = {w0_i, w1_i};
    endcase
  end
endmodule

// File: rtl/blk_decomp.sv
module blk_decomp
  import blkd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int N_DW       = 16,
  parameter int LOC_W      = 32,
  parameter int ADDR_SHIFT = 3,
  localparam int DW_W   = 2 * WORD_W,
  localparam int HDR_W  = 2 * N_DW,
  localparam int IDX_W  = $clog2(N_DW),
  localparam int ADDR_W = LOC_W + ADDR_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_valid_i,
  output logic              blk_ready_o,
  input  logic [1:0]        blk_state_i,
  input  logic [HDR_W-1:0]  blk_hdr_i,
  input  logic [LOC_W-1:0]  blk_loc_i,
  output logic [ADDR_W-1:0] blk_addr_o,
  input  logic              pay_valid_i,
  output logic              pay_ready_o,
  input  logic [WORD_W-1:0] pay_data_i,
  output logic              dw_valid_o,
  input  logic              dw_ready_i,
  output logic [DW_W-1:0]   dw_data_o,
  output logic              dw_last_o
);
  logic              busy_q;
  blk_state_e        state_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        got_q;
  logic [WORD_W-1:0] w0_q, w1_q;
  logic              out_v_q;
  logic [DW_W-1:0]   out_q;

  pat_code_e       code;
  logic [1:0]      need;
  logic [DW_W-1:0] dw_asm;
  logic            blk_fire, pay_fire, form, dw_fire, is_last;

  blkd_code_sel #(.N_DW(N_DW)) u_sel (
    .hdr_i   (hdr_q),
    .idx_i   (idx_q),
    .state_i (state_q),
    .code_o  (code),
    .need_o  (need)
  );

  blkd_dw_asm #(.WORD_W(WORD_W)) u_asm (
    .code_i (code),
    .var2_i (state_q == ST_VAR2),
    .w0_i   (w0_q),
    .w1_i   (w1_q),
    .dw_o   (dw_asm)
  );

  assign blk_ready_o = !busy_q;
  assign pay_ready_o = busy_q && !out_v_q && (got_q < need);
  assign blk_fire    = blk_valid_i && blk_ready_o;
  assign pay_fire    = pay_valid_i && pay_ready_o;
  assign form        = busy_q && !out_v_q && (got_q == need);
  assign dw_fire     = out_v_q && dw_ready_i;
  assign is_last     = idx_q == IDX_W'(N_DW - 1);

  assign blk_addr_o = addr_q;
  assign dw_valid_o = out_v_q;
  assign dw_data_o  = out_q;
  assign dw_last_o  = out_v_q && is_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      state_q <= ST_ZERO;
      hdr_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      got_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      if (blk_fire) begin
        busy_q  <= 1'b1;
        state_q <= blk_state_e'(blk_state_i);
        hdr_q   <= blk_hdr_i;
        addr_q  <= ADDR_W'(blk_loc_i) << ADDR_SHIFT;
        idx_q   <= '0;
        got_q   <= '0;
      end
      if (pay_fire) begin
        if (got_q == 2'd0) w0_q <= pay_data_i;
        else               w1_q <= pay_data_i;
        got_q <= got_q + 2'd1;
      end
      if (form) begin
        out_v_q <= 1'b1;
        out_q   <= dw_asm;
      end
      if (dw_fire) begin
        out_v_q <= 1'b0;
        got_q   <= '0;
        idx_q   <= idx_q + 1'b1;
        if (is_last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_decomp_chk.sv
module blk_decomp_chk #(
  parameter int DW_W   = 64,
  parameter int ADDR_W = 35
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              blk_ready_o,
  input logic              pay_ready_o,
  input logic              dw_valid_o,
  input logic              dw_ready_i,
  input logic [DW_W-1:0]   dw_data_o,
  input logic              dw_last_o,
  input logic [ADDR_W-1:0] blk_addr_o,
  input logic              zero_busy_i
);
  a_r11_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_valid_o && !dw_ready_i |=> dw_valid_o);

  a_r11_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_valid_o && !dw_ready_i |=> $stable(dw_data_o));

  a_r10_no_accept_mid_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_valid_o |-> !blk_ready_o);

  a_r10_no_pay_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> !blk_ready_o);

  a_r10_free_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_last_o && dw_ready_i |=> blk_ready_o);

  a_r2_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_last_o |-> dw_valid_o);

  a_r9_zero_no_pay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_busy_i |-> !pay_ready_o);

  a_r1_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_ready_o && $past(!blk_ready_o) |-> $stable(blk_addr_o));
endmodule

bind blk_decomp blk_decomp_chk #(.DW_W(DW_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blk_ready_o (blk_ready_o),
  .pay_ready_o (pay_ready_o),
  .dw_valid_o  (dw_valid_o),
  .dw_ready_i  (dw_ready_i),
  .dw_data_o   (dw_data_o),
  .dw_last_o   (dw_last_o),
  .blk_addr_o  (blk_addr_o),
  .zero_busy_i (busy_q && (state_q == blkd_pkg::ST_ZERO))
);

// File: tb/blk_decomp_tb_top.sv
module blk_decomp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        blk_valid_i = 1'b0;
  logic        blk_ready_o;
  logic [1:0]  blk_state_i = '0;
  logic [31:0] blk_hdr_i = '0;
  logic [31:0] blk_loc_i = '0;
  logic [34:0] blk_addr_o;
  logic        pay_valid_i = 1'b0;
  logic        pay_ready_o;
  logic [31:0] pay_data_i = '0;
  logic        dw_valid_o;
  logic        dw_ready_i = 1'b0;
  logic [63:0] dw_data_o;
  logic        dw_last_o;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  blk_decomp dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  // behavioural model: build payload and expected double-words
  task automatic run_block(input logic [1:0] st, input logic [31:0] hdr,
                           input logic [31:0] loc, input int id, input bit gaps);
    logic [31:0] pay[$];
    logic [63:0] exp_q[$];
    string tag_q[$];
    int pidx = 0, n = 0, k = 0, guard = 0;
    bit accepted = 0, busy_ok = 1, stall = 0;
    logic [63:0] held = '0;
    logic [1:0] c;
    logic [31:0] a, b;
    for (int i = 0; i < 16; i++) begin
      c = (st == 2'b10) ? 2'b11 : (st == 2'b11) ? 2'b00 : hdr[31-2*i -: 2];
      case (c)
        2'b00: begin exp_q.push_back(64'h0); tag_q.push_back(st == 2'b11 ? "R9" : "R3"); end
        2'b01: begin
          a = {8'hA0 | 8'(id), 8'(k), 8'h5C, 8'(k*7+1)}; k++; pay.push_back(a);
          exp_q.push_back({32'h0, a}); tag_q.push_back("R4");
        end
        2'b10: begin
          a = {8'hA0 | 8'(id), 8'(k), 8'h5C, 8'(k*7+1)}; k++; pay.push_back(a);
          exp_q.push_back(st == 2'b01 ? {a, 32'h0} : {a, a});
          tag_q.push_back(st == 2'b01 ? "R6" : "R5");
        end
        default: begin
          a = {8'hA0 | 8'(id), 8'(k), 8'h5C, 8'(k*7+1)}; k++; pay.push_back(a);
          b = {8'hA0 | 8'(id), 8'(k), 8'h5C, 8'(k*7+1)}; k++; pay.push_back(b);
          exp_q.push_back({a, b}); tag_q.push_back(st == 2'b10 ? "R8" : "R7");
        end
      endcase
    end
    while (n < 16 && guard < 2000) begin
      @(negedge clk_i);
      guard++;
      if (stall) check(dw_valid_o && dw_data_o == held, "R11 hold under stall", dw_data_o, held);
      blk_valid_i = !accepted;
      blk_state_i = st; blk_hdr_i = hdr; blk_loc_i = loc;
      pay_valid_i = (pidx < pay.size()) && (!gaps || (cyc % 4 != 1));
      pay_data_i  = (pidx < pay.size()) ? pay[pidx] : 32'h0;
      dw_ready_i  = !gaps || (cyc % 3 != 2);
      #1;
      if (accepted && blk_ready_o) busy_ok = 0;
      if (pay_valid_i && pay_ready_o) pidx++;
      stall = dw_valid_o && !dw_ready_i;
      held  = dw_data_o;
      if (dw_valid_o && dw_ready_i) begin
        check(dw_data_o == exp_q[n], tag_q[n], dw_data_o, exp_q[n]);
        check(dw_last_o == (n == 15), "R2 last flag", 64'(dw_last_o), 64'(n == 15));
        if (n == 0) check(blk_addr_o == {loc, 3'b000}, "R1 address", 64'(blk_addr_o), 64'({loc, 3'b000}));
        n++;
      end
      if (blk_valid_i && blk_ready_o) accepted = 1;
    end
    blk_valid_i = 0; pay_valid_i = 0;
    check(n == 16, "R2 count", 64'(n), 64'd16);
    check(busy_ok, "R10 busy during block", 64'(busy_ok), 64'd1);
    check(pidx == pay.size(), "R10 payload words taken", 64'(pidx), 64'(pay.size()));
    @(negedge clk_i);
    check(blk_ready_o && !pay_ready_o && !dw_valid_o, "R10 ready after last",
          64'({blk_ready_o, pay_ready_o, dw_valid_o}), 64'b100);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk_i);
    check(blk_ready_o && !dw_valid_o && !pay_ready_o, "R12 reset state",
          64'({blk_ready_o, dw_valid_o, pay_ready_o}), 64'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_block(2'b00, 32'h1B1B_1B1B, 32'h4fd1_276a, 1, 0);   // R3 R4 R5 R7
    run_block(2'b01, 32'h1B1B_1B1B, 32'h0000_0001, 2, 0);   // R6 variant II
    run_block(2'b01, 32'hE4E4_0FF0, 32'h1234_5678, 3, 1);   // R11 with gaps
    run_block(2'b10, 32'h0000_0000, 32'h0000_0100, 4, 1);   // R8 raw
    run_block(2'b11, 32'hFFFF_FFFF, 32'h0000_0000, 5, 1);   // R9 all zero
    run_block(2'b00, 32'h0000_0000, 32'hFFFF_FFFF, 6, 0);   // R3 only zeros, R1 top address
    run_block(2'b00, 32'hFFFF_FFFF, 32'h8000_0000, 7, 1);   // R7 full
    run_block(2'b01, 32'hAAAA_5555, 32'h0F0F_0F0F, 8, 0);   // R6 R4 R2 order
    done = 1;
    finish_run();
  end
endmodule